// File: doc/BRIEF.md
# Hashed DRAM Address Translator

This block converts between a flat 32-bit physical address and the coordinates of a single-channel DRAM: bank, row, column and byte offset. It works in both directions. A mode bit travels with each transfer and selects the direction. In decode mode an address goes in and its coordinates come out. In encode mode coordinates go in and the address comes out.

Elaboration parameters place the bank and row fields. Each field has an ordered list of address bit positions, and entry k of a list feeds bit k of that field. A list of pairs sets the bank hashing. Each pair couples one bank address bit to one row address bit. Before the fields are gathered, each paired bank bit is replaced by its XOR with its partner row bit. The column field has no list of its own. It collects every address bit that is not a byte, bank or row bit, with bit 31 also excluded, in ascending address order. Encoding scatters the fields back to their positions and applies the same pair XORs. Encoding therefore undoes decoding exactly.

Transfers use a valid/ready handshake. A result is registered and appears one cycle after it is accepted. It stays on the outputs until the consumer takes it.

Top module: `amap_xlate`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A transfer accepted on a clock edge (`in_valid` and `in_ready` both high) shows its result with `out_valid` high in the cycle right after that edge.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every output holds its value.
- R4: The byte offset is address bits 2..0 in both directions. Decode copies `in_addr[2:0]` to `out_byte`, and encode copies `in_byte` to `out_addr[2:0]`.
- R5: In decode, bank bit k is the address bit at bank position k, XORed with its partner row bit when that bank bit has a pair. Default positions are bank 27, 28, 29 and row 13..26, with pairs (27,13) and (28,14). So `out_bank = {a[29], a[28]^a[14], a[27]^a[13]}`.
- R6: In decode, row bit k is the address bit at row position k and is never altered by hashing. By default `out_row = a[26:13]`.
- R7: In decode, column bits are the unused address bits in ascending order. By default this is `out_col = {a[30], a[12:3]}`, and address bit 31 affects no output field.
- R8: Encoding is the inverse of decoding. Encoding the fields decoded from any address with bit 31 clear returns that address.
- R9: With the pair count parameter `XOR_USED` set to 0, the mapping is plain bit selection. With default positions, decoding `(1<<27)|(1<<13)` then gives bank 1 and row 1.
- R10: `in_mode` 0 selects decode and 1 selects encode. The mode of each transfer is returned on `out_mode` with its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 1 | 0 decode, 1 encode |
| in_addr | input | 32 | Address to decode |
| in_bank | input | BANK_BITS | Bank to encode |
| in_row | input | ROW_BITS | Row to encode |
| in_col | input | COL_BITS | Column to encode |
| in_byte | input | 3 | Byte offset to encode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_mode | output | 1 | Mode of the result |
| out_addr | output | 32 | Encoded address (decode: echo of input) |
| out_bank | output | BANK_BITS | Decoded bank (encode: echo) |
| out_row | output | ROW_BITS | Decoded row (encode: echo) |
| out_col | output | COL_BITS | Decoded column (encode: echo) |
| out_byte | output | 3 | Byte offset |

## Verification
Every result is due exactly one cycle after its request is accepted. The driver records the acceptance cycle next to each expected item in the scoreboard. The monitor checks that the first cycle showing a new result is that cycle plus one. Outputs are sampled three quarters into each cycle, clear of the edge. This ensures that an acceptance seen by the driver and a result seen by the monitor refer to the same edge. Random backpressure makes results wait, and during a stall every later sample must match the held values until the result is consumed.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int ADDR_W    = 32;
    localparam int POS_W     = 5;
    localparam int BYTE_BITS = 3;

    typedef enum logic {
        XL_DECODE = 1'b0,
        XL_ENCODE = 1'b1
    } xl_mode_e;

    // Address position of column bit k: the k-th set bit of the free mask,
    // counted from bit 0 upward.
    function automatic int col_src(logic [ADDR_W-1:0] free_mask, int k);
        int n;
        n = 0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (free_mask[i]) begin
                if (n == k) return i;
                n++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/amap_xor_hash.sv
module amap_xor_hash #(
    parameter int XOR_SLOTS = 2,
    parameter int XOR_USED  = 2,
    parameter logic [2*XOR_SLOTS*amap_pkg::POS_W-1:0] XOR_POS =
        {5'd14, 5'd13, 5'd28, 5'd27}
) (
    input  logic [amap_pkg::ADDR_W-1:0] addr_i,
    output logic [amap_pkg::ADDR_W-1:0] addr_o
);
    localparam int PW = amap_pkg::POS_W;

    generate
        if (XOR_USED == 0) begin : g_plain
            assign addr_o = addr_i;
        end else begin : g_hash
            // Pairs applied in list order; bank half first, row half second.
            always_comb begin
                addr_o = addr_i;
                for (int i = 0; i < XOR_USED; i++) begin
                    addr_o[XOR_POS[i*PW +: PW]] =
                        addr_o[XOR_POS[i*PW +: PW]] ^
                        addr_o[XOR_POS[(XOR_SLOTS+i)*PW +: PW]];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/amap_gather.sv
module amap_gather #(
    parameter int BANK_BITS = 3,
    parameter int ROW_BITS  = 14,
    parameter int COL_BITS  = 11,
    parameter logic [BANK_BITS*amap_pkg::POS_W-1:0] BANK_POS = '0,
    parameter logic [ROW_BITS*amap_pkg::POS_W-1:0]  ROW_POS  = '0,
    parameter logic [amap_pkg::ADDR_W-1:0]          FREE_MASK = '0
) (
    input  logic [amap_pkg::ADDR_W-1:0] addr_i,
    output logic [BANK_BITS-1:0]        bank_o,
    output logic [ROW_BITS-1:0]         row_o,
    output logic [COL_BITS-1:0]         col_o
);
    localparam int PW = amap_pkg::POS_W;

    always_comb begin
        for (int k = 0; k < BANK_BITS; k++) bank_o[k] = addr_i[BANK_POS[k*PW +: PW]];
        for (int k = 0; k < ROW_BITS; k++)  row_o[k]  = addr_i[ROW_POS[k*PW +: PW]];
        for (int k = 0; k < COL_BITS; k++)  col_o[k]  = addr_i[amap_pkg::col_src(FREE_MASK, k)];
    end
endmodule

// File: rtl/amap_scatter.sv
module amap_scatter #(
    parameter int BANK_BITS = 3,
    parameter int ROW_BITS  = 14,
    parameter int COL_BITS  = 11,
    parameter logic [BANK_BITS*amap_pkg::POS_W-1:0] BANK_POS = '0,
    parameter logic [ROW_BITS*amap_pkg::POS_W-1:0]  ROW_POS  = '0,
    parameter logic [amap_pkg::ADDR_W-1:0]          FREE_MASK = '0
) (
    input  logic [BANK_BITS-1:0]           bank_i,
    input  logic [ROW_BITS-1:0]            row_i,
    input  logic [COL_BITS-1:0]            col_i,
    input  logic [amap_pkg::BYTE_BITS-1:0] byte_i,
    output logic [amap_pkg::ADDR_W-1:0]    addr_o
);
    localparam int PW = amap_pkg::POS_W;

    always_comb begin
        addr_o = '0;
        for (int k = 0; k < BANK_BITS; k++) addr_o[BANK_POS[k*PW +: PW]] = bank_i[k];
        for (int k = 0; k < ROW_BITS; k++)  addr_o[ROW_POS[k*PW +: PW]]  = row_i[k];
        for (int k = 0; k < COL_BITS; k++)  addr_o[amap_pkg::col_src(FREE_MASK, k)] = col_i[k];
        addr_o[amap_pkg::BYTE_BITS-1:0] = byte_i;
    end
endmodule

// File: rtl/amap_xlate.sv
module amap_xlate #(
    parameter int BANK_BITS = 3,
    parameter int ROW_BITS  = 14,
    parameter logic [BANK_BITS*amap_pkg::POS_W-1:0] BANK_POS = {5'd29, 5'd28, 5'd27},
    parameter logic [ROW_BITS*amap_pkg::POS_W-1:0]  ROW_POS  =
        {5'd26, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21, 5'd20,
         5'd19, 5'd18, 5'd17, 5'd16, 5'd15, 5'd14, 5'd13},
    parameter int XOR_SLOTS = 2,
    parameter int XOR_USED  = 2,
    parameter logic [2*XOR_SLOTS*amap_pkg::POS_W-1:0] XOR_POS =
        {5'd14, 5'd13, 5'd28, 5'd27},
    localparam int COL_BITS = amap_pkg::ADDR_W - amap_pkg::BYTE_BITS - 1 - BANK_BITS - ROW_BITS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic                           in_mode,
    input  logic [amap_pkg::ADDR_W-1:0]    in_addr,
    input  logic [BANK_BITS-1:0]           in_bank,
    input  logic [ROW_BITS-1:0]            in_row,
    input  logic [COL_BITS-1:0]            in_col,
    input  logic [amap_pkg::BYTE_BITS-1:0] in_byte,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic                           out_mode,
    output logic [amap_pkg::ADDR_W-1:0]    out_addr,
    output logic [BANK_BITS-1:0]           out_bank,
    output logic [ROW_BITS-1:0]            out_row,
    output logic [COL_BITS-1:0]            out_col,
    output logic [amap_pkg::BYTE_BITS-1:0] out_byte
);
    import amap_pkg::*;

    localparam int PW = POS_W;

    // Column bits: everything not byte, bank, row, nor the top bit.
    function automatic logic [ADDR_W-1:0] free_bits();
        logic [ADDR_W-1:0] m;
        m = '1;
        m[BYTE_BITS-1:0] = '0;
        m[ADDR_W-1] = 1'b0;
        for (int k = 0; k < BANK_BITS; k++) m[BANK_POS[k*PW +: PW]] = 1'b0;
        for (int k = 0; k < ROW_BITS; k++)  m[ROW_POS[k*PW +: PW]]  = 1'b0;
        return m;
    endfunction

    localparam logic [ADDR_W-1:0] FREE_MASK = free_bits();

    typedef struct packed {
        logic                 valid;
        xl_mode_e             mode;
        logic [ADDR_W-1:0]    addr;
        logic [BANK_BITS-1:0] bank;
        logic [ROW_BITS-1:0]  row;
        logic [COL_BITS-1:0]  col;
        logic [BYTE_BITS-1:0] byte_off;
    } res_t;

    res_t res_d, res_q;

    logic [ADDR_W-1:0]    scat_addr, hash_in, hash_out;
    logic [BANK_BITS-1:0] g_bank;
    logic [ROW_BITS-1:0]  g_row;
    logic [COL_BITS-1:0]  g_col;
    xl_mode_e             req_mode;

    assign req_mode = xl_mode_e'(in_mode);

    amap_scatter #(
        .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
        .BANK_POS(BANK_POS), .ROW_POS(ROW_POS), .FREE_MASK(FREE_MASK)
    ) u_scatter (
        .bank_i(in_bank), .row_i(in_row), .col_i(in_col), .byte_i(in_byte),
        .addr_o(scat_addr)
    );

    // One shared hash stage: its input is the raw address or the scattered one.
    assign hash_in = (req_mode == XL_ENCODE) ? scat_addr : in_addr;

    amap_xor_hash #(
        .XOR_SLOTS(XOR_SLOTS), .XOR_USED(XOR_USED), .XOR_POS(XOR_POS)
    ) u_hash (
        .addr_i(hash_in), .addr_o(hash_out)
    );

    amap_gather #(
        .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
        .BANK_POS(BANK_POS), .ROW_POS(ROW_POS), .FREE_MASK(FREE_MASK)
    ) u_gather (
        .addr_i(hash_out), .bank_o(g_bank), .row_o(g_row), .col_o(g_col)
    );

    always_comb begin
        res_d    = res_q;
        in_ready = !res_q.valid || out_ready;
        if (in_ready) begin
            res_d.valid = in_valid;
            if (in_valid) begin
                res_d.mode = req_mode;
                if (req_mode == XL_DECODE) begin
                    res_d.addr     = in_addr;
                    res_d.bank     = g_bank;
                    res_d.row      = g_row;
                    res_d.col      = g_col;
                    res_d.byte_off = in_addr[BYTE_BITS-1:0];
                end else begin
                    res_d.addr     = hash_out;
                    res_d.bank     = in_bank;
                    res_d.row      = in_row;
                    res_d.col      = in_col;
                    res_d.byte_off = in_byte;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_mode  = res_q.mode;
    assign out_addr  = res_q.addr;
    assign out_bank  = res_q.bank;
    assign out_row   = res_q.row;
    assign out_col   = res_q.col;
    assign out_byte  = res_q.byte_off;

    // R2
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_bank)
            && $stable(out_row) && $stable(out_col) && $stable(out_byte) && $stable(out_mode));

    // R4
    byte_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_mode |=> out_byte == $past(in_addr[BYTE_BITS-1:0]));

    // R4
    byte_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode |=> out_addr[BYTE_BITS-1:0] == $past(in_byte));

    // R6
    row_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_mode |=> out_row[0] == $past(in_addr[ROW_POS[PW-1:0]]));

    // R10
    mode_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_mode == $past(in_mode));
endmodule

// File: tb/tb_amap_xlate.sv
module tb_amap_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_mode = 1'b0, out_ready = 1'b1;
    logic [31:0] in_addr = '0;
    logic [2:0]  in_bank = '0, in_byte = '0;
    logic [13:0] in_row = '0;
    logic [10:0] in_col = '0;
    logic        in_ready, out_valid, out_mode;
    logic [31:0] out_addr;
    logic [2:0]  out_bank, out_byte;
    logic [13:0] out_row;
    logic [10:0] out_col;

    logic        p_in_valid = 1'b0, p_in_mode = 1'b0;
    logic [31:0] p_in_addr = '0;
    logic [2:0]  p_in_bank = '0;
    logic [13:0] p_in_row = '0;
    logic        p_in_ready, p_out_valid, p_out_mode;
    logic [31:0] p_out_addr;
    logic [2:0]  p_out_bank, p_out_byte;
    logic [13:0] p_out_row;
    logic [10:0] p_out_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    amap_xlate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_addr(in_addr), .in_bank(in_bank), .in_row(in_row),
        .in_col(in_col), .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
        .out_mode(out_mode), .out_addr(out_addr), .out_bank(out_bank), .out_row(out_row),
        .out_col(out_col), .out_byte(out_byte)
    );

    amap_xlate #(.XOR_USED(0)) dut_plain (
        .clk(clk), .rst_n(rst_n), .in_valid(p_in_valid), .in_ready(p_in_ready),
        .in_mode(p_in_mode), .in_addr(p_in_addr), .in_bank(p_in_bank), .in_row(p_in_row),
        .in_col(11'd0), .in_byte(3'd0), .out_valid(p_out_valid), .out_ready(1'b1),
        .out_mode(p_out_mode), .out_addr(p_out_addr), .out_bank(p_out_bank),
        .out_row(p_out_row), .out_col(p_out_col), .out_byte(p_out_byte)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit stall_on = 1'b0;

    typedef struct {
        logic        mode;
        logic [31:0] addr;
        logic [2:0]  bank;
        logic [13:0] row;
        logic [10:0] col;
        logic [2:0]  byt;
        int          acc;
    } item_t;

    item_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference mapping for the default parameters, taken from R5..R7.
    function automatic item_t ref_decode(logic [31:0] a);
        item_t it;
        logic [31:0] h;
        h = a;
        h[27] = a[27] ^ a[13];
        h[28] = a[28] ^ a[14];
        it.mode = 1'b0; it.addr = a;
        it.bank = h[29:27]; it.row = a[26:13];
        it.col = {a[30], a[12:3]}; it.byt = a[2:0]; it.acc = 0;
        return it;
    endfunction

    task automatic send(item_t it);
        @(negedge clk);
        in_valid = 1'b1; in_mode = it.mode;
        in_addr = it.mode ? 32'h0 : it.addr;
        in_bank = it.bank; in_row = it.row; in_col = it.col; in_byte = it.byt;
        forever begin
            #(CLK_PERIOD/4);
            if (in_ready) begin
                it.acc = cyc;
                sb.push_back(it);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (sb.size() != 0 && n < 1000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : ready_gen
        forever begin
            @(negedge clk);
            out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    initial begin : monitor
        bit held;
        item_t e;
        logic [31:0] h_addr;
        logic [2:0]  h_bank;
        logic [13:0] h_row;
        logic [10:0] h_col;
        held = 1'b0;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (!rst_n) begin
                held = 1'b0;
            end else if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "result without request", 32'd1, 32'd0);
                end else begin
                    e = sb[0];
                    if (held) begin
                        check(out_addr == h_addr && out_bank == h_bank && out_row == h_row
                              && out_col == h_col, "R3", "held output", out_addr, h_addr);
                    end else begin
                        check(cyc == e.acc + 1, "R2", "latency cycle", cyc, e.acc + 1);
                    end
                    if (out_ready) begin
                        check(out_mode == e.mode, "R10", "mode", {31'd0, out_mode}, {31'd0, e.mode});
                        if (e.mode) begin
                            check(out_addr == e.addr, "R8", "encoded address", out_addr, e.addr);
                            check(out_addr[2:0] == e.byt, "R4", "encode byte", out_addr[2:0], e.byt);
                        end else begin
                            check(out_bank == e.bank, "R5", "bank", out_bank, e.bank);
                            check(out_row == e.row, "R6", "row", out_row, e.row);
                            check(out_col == e.col, "R7", "column", out_col, e.col);
                            check(out_byte == e.byt, "R4", "decode byte", out_byte, e.byt);
                        end
                        void'(sb.pop_front());
                        held = 1'b0;
                    end else begin
                        held = 1'b1;
                        h_addr = out_addr; h_bank = out_bank; h_row = out_row; h_col = out_col;
                    end
                end
            end else begin
                if (held) check(1'b0, "R3", "valid dropped while stalled", 32'd0, 32'd1);
                held = 1'b0;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stimulus
        item_t it;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R1
        check(out_valid == 1'b0, "R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);

        // Directed decodes: R4..R7 corner patterns.
        send(ref_decode(32'h0000_0000));
        send(ref_decode(32'h0000_2000));   // bit13: row 1, bank bit0 hashed to 1 (R5)
        send(ref_decode(32'h0800_2000));   // bits27,13 cancel (R5)
        send(ref_decode(32'h1000_4000));   // bits28,14 cancel (R5)
        send(ref_decode(32'h2000_0000));   // bank bit2 plain (R5)
        send(ref_decode(32'h4000_0000));   // column top bit from address 30 (R7)
        send(ref_decode(32'h8000_0000));   // bit31 ignored: all zero (R7)
        send(ref_decode(32'h0000_0007));   // byte offset (R4)
        send(ref_decode(32'h07FF_E000));   // full row (R6)
        send(ref_decode(32'h0000_1FF8));   // low column bits (R7)
        idle();
        drain();

        // Round trip under random backpressure (R8, R3).
        stall_on = 1'b1;
        for (int i = 0; i < 200; i++) begin
            a = $urandom & 32'h7FFF_FFFF;
            it = ref_decode(a);
            send(it);
            it.mode = 1'b1;
            send(it);
        end
        idle();
        drain();
        stall_on = 1'b0;

        // R9: plain selection with no pairs.
        @(negedge clk);
        p_in_valid = 1'b1; p_in_mode = 1'b0; p_in_addr = 32'h0800_2000;
        @(negedge clk);
        p_in_valid = 1'b0;
        #(CLK_PERIOD/4);
        check(p_out_valid == 1'b1, "R9", "plain valid", {31'd0, p_out_valid}, 32'd1);
        check(p_out_bank == 3'd1, "R9", "plain bank", {29'd0, p_out_bank}, 32'd1);
        check(p_out_row == 14'd1, "R9", "plain row", {18'd0, p_out_row}, 32'd1);
        @(negedge clk);
        p_in_valid = 1'b1; p_in_mode = 1'b1; p_in_bank = 3'd1; p_in_row = 14'd1;
        @(negedge clk);
        p_in_valid = 1'b0;
        #(CLK_PERIOD/4);
        check(p_out_addr == 32'h0800_2000, "R9", "plain encode", p_out_addr, 32'h0800_2000);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule